// File: doc/BRIEF.md
# PWM Output Pin Conditioning Stage

This block sits between a capture/compare/PWM waveform engine and six tri-stateable output pads, A through F. For each pad it produces a drive value and an output enable. The pads fall into two groups: A, C and E (the even group), and B, D and F (the odd group). Each group has its own polarity setting and its own shutdown-state code. A shutdown event input overrides the waveform immediately. The group's code then decides whether the pads are forced to their active level, forced to their inactive level, or released to high impedance.

A triggered-mode enable, combined with a hold-until-trigger bit, can keep every pad undriven after reset until the first trigger pulse arrives. A registered armed flag records that pulse and keeps it until triggered mode is switched off. Each pad also has its own enable. A disabled pad is never driven. Generating the waveform, timing the one-shot and decoding the register bus all happen outside this block.

Top module: `pwm_pin_cond`

## Requirements
- R1: With shutdown low and no hold active, every enabled pad has pad_oe=1 and pad_out equal to its wave_in bit XOR its group's polarity bit.
- R2: Pads 0, 2 and 4 (A, C, E) use pol_ace and sd_mode_ace. Pads 1, 3 and 5 (B, D, F) use pol_bdf and sd_mode_bdf. The two groups' settings act independently.
- R3: While shutdown_in is 1 and a group's code is 2'b11, each enabled pad of that group has pad_oe=1 and pad_out at the active level, which is NOT polarity. This takes effect in the same cycle, with no clock edge needed.
- R4: While shutdown_in is 1 and a group's code is 2'b10, each enabled pad of that group has pad_oe=1 and pad_out at the inactive level, which equals the polarity bit.
- R5: While shutdown_in is 1 and a group's code is 2'b00 or 2'b01, that group's pads have pad_oe=0 and pad_out=0.
- R6: When shutdown_in returns to 0, the pads follow the conditioned waveform again in that same cycle.
- R7: While hold_until_trig=1, trig_mode_en=1 and the armed flag is clear, with shutdown low, all pads have pad_oe=0 and pad_out=0.
- R8: A clock edge with trig_in=1 and trig_mode_en=1 sets the armed flag. From the next cycle on, the pads behave as in R1, even after trig_in falls.
- R9: A clock edge with trig_mode_en=0 clears the armed flag. Re-enabling triggered mode with the hold bit set holds the pads again until a new trigger arrives.
- R10: With hold_until_trig=0 or trig_mode_en=0, no hold applies and trig_in has no effect on the pads.
- R11: Shutdown takes priority over the trigger hold. The R3 to R5 behaviour applies even while the pads are held.
- R12: A pad whose pin_en bit is 0 always has pad_oe=0 and pad_out=0. More generally, pad_out is 0 whenever pad_oe is 0.
- R13: A clock edge with rst_n=0 clears the armed flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wave_in | input | NUM_PINS | Raw waveform bits, bit i for pad i (0=A ... 5=F) |
| pin_en | input | NUM_PINS | Per-pad enable |
| shutdown_in | input | 1 | Shutdown event, active high |
| trig_in | input | 1 | Trigger pulse |
| trig_mode_en | input | 1 | Triggered mode enable |
| hold_until_trig | input | 1 | Hold pads undriven until triggered (triggered mode only) |
| pol_ace | input | 1 | Even group polarity, 1 = active-low |
| pol_bdf | input | 1 | Odd group polarity, 1 = active-low |
| sd_mode_ace | input | 2 | Even group shutdown code: 11 active, 10 inactive, 0x high impedance |
| sd_mode_bdf | input | 2 | Odd group shutdown code, same encoding |
| pad_out | output | NUM_PINS | Pad drive value |
| pad_oe | output | NUM_PINS | Pad output enable |

## Verification
The assertions check the following on every cycle:
- a disabled pad never drives;
- the forced active and inactive levels of the even group under shutdown;
- the high-impedance release of the odd group;
- the pass-through of the waveform when no hold applies;
- that the pads are held on the cycle after triggered mode is re-entered, and released on the cycle after a trigger.

Only the bench scenarios show some of the other behaviour:
- the order of events across cycles, such as the hold lasting through many cycles until a trigger and persisting after it;
- that the armed flag is cleared by reset;
- that both groups behave independently across all code and polarity combinations;
- that shutdown overrides a held state.

// File: rtl/pwm_pin_cond_pkg.sv
// Package: shared encodings for the PWM pad conditioning stage.
// Assumes two pad groups; pad i belongs to group (i % 2).
package pwm_pin_cond_pkg;

    localparam int NUM_GROUPS = 2;

    // Shutdown-state code of one pad group.
    typedef enum logic [1:0] {
        SD_HIZ_A  = 2'b00,
        SD_HIZ_B  = 2'b01,
        SD_INACT  = 2'b10,
        SD_ACTIVE = 2'b11
    } sd_mode_e;

    // Settings that apply to every pad of one group.
    typedef struct packed {
        logic     active_low;
        sd_mode_e sd_mode;
    } grp_cfg_t;

    // Condition applied to one pad in one cycle.
    typedef enum logic [1:0] {
        PAD_FOLLOW,
        PAD_FORCE_ACT,
        PAD_FORCE_INACT,
        PAD_RELEASE
    } pad_state_e;

endpackage

// File: rtl/pwm_trig_arm.sv
// Module: pwm_trig_arm
// Holds the armed flag for triggered mode and derives the hold condition.
// Assumes trig_in is synchronous to clk; a one-cycle pulse is enough to arm.
module pwm_trig_arm (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_in,
    input  logic trig_mode_en,
    input  logic hold_until_trig,
    output logic hold_active
);

    logic armed_q;

    // Armed flag: cleared by reset or by leaving triggered mode, set by a trigger.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
        end else if (!trig_mode_en) begin
            armed_q <= 1'b0;
        end else if (trig_in) begin
            armed_q <= 1'b1;
        end
    end

    // Pads are held while the hold is requested in triggered mode and not yet armed.
    always_comb begin
        hold_active = hold_until_trig & trig_mode_en & ~armed_q;
    end

endmodule

// File: rtl/pwm_pad_slice.sv
// Module: pwm_pad_slice
// Conditions one pad: decides the pad state and derives drive value and enable.
// Assumes the group settings are stable while used; purely combinational.
module pwm_pad_slice
    import pwm_pin_cond_pkg::*;
(
    input  logic     wave,
    input  logic     en,
    input  logic     shutdown,
    input  logic     hold,
    input  grp_cfg_t cfg,
    output logic     drive,
    output logic     oe
);

    pad_state_e state;

    // Pad state selection: enable, then shutdown, then hold, then waveform.
    always_comb begin
        if (!en) begin
            state = PAD_RELEASE;
        end else if (shutdown) begin
            unique case (cfg.sd_mode)
                SD_ACTIVE: state = PAD_FORCE_ACT;
                SD_INACT:  state = PAD_FORCE_INACT;
                default:   state = PAD_RELEASE;
            endcase
        end else if (hold) begin
            state = PAD_RELEASE;
        end else begin
            state = PAD_FOLLOW;
        end
    end

    // Pad drive and enable derived from the selected state and polarity.
    always_comb begin
        unique case (state)
            PAD_FOLLOW:      begin drive = wave ^ cfg.active_low; oe = 1'b1; end
            PAD_FORCE_ACT:   begin drive = ~cfg.active_low;       oe = 1'b1; end
            PAD_FORCE_INACT: begin drive = cfg.active_low;        oe = 1'b1; end
            default:         begin drive = 1'b0;                  oe = 1'b0; end
        endcase
    end

endmodule

// File: rtl/pwm_pin_cond.sv
// Module: pwm_pin_cond (top)
// Output pad conditioning for a PWM engine: polarity, shutdown state,
// trigger hold and per-pad enable for NUM_PINS pads in two groups.
// Assumes all inputs are synchronous to clk; shutdown acts combinationally.
module pwm_pin_cond
    import pwm_pin_cond_pkg::*;
#(
    parameter int NUM_PINS = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] wave_in,
    input  logic [NUM_PINS-1:0] pin_en,
    input  logic                shutdown_in,
    input  logic                trig_in,
    input  logic                trig_mode_en,
    input  logic                hold_until_trig,
    input  logic                pol_ace,
    input  logic                pol_bdf,
    input  logic [1:0]          sd_mode_ace,
    input  logic [1:0]          sd_mode_bdf,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] pad_oe
);

    grp_cfg_t grp_cfg [NUM_GROUPS];
    logic     hold_active;

    // Gather per-group settings into one table indexed by group.
    always_comb begin
        grp_cfg[0].active_low = pol_ace;
        grp_cfg[0].sd_mode    = sd_mode_e'(sd_mode_ace);
        grp_cfg[1].active_low = pol_bdf;
        grp_cfg[1].sd_mode    = sd_mode_e'(sd_mode_bdf);
    end

    pwm_trig_arm u_arm (
        .clk             (clk),
        .rst_n           (rst_n),
        .trig_in         (trig_in),
        .trig_mode_en    (trig_mode_en),
        .hold_until_trig (hold_until_trig),
        .hold_active     (hold_active)
    );

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pad
        localparam int GRP = i % NUM_GROUPS;
        pwm_pad_slice u_slice (
            .wave     (wave_in[i]),
            .en       (pin_en[i]),
            .shutdown (shutdown_in),
            .hold     (hold_active),
            .cfg      (grp_cfg[GRP]),
            .drive    (pad_out[i]),
            .oe       (pad_oe[i])
        );
    end

endmodule

// File: rtl/pwm_pin_cond_chk.sv
// Module: pwm_pin_cond_chk
// Checker attached to pwm_pin_cond; it observes only the top-level ports.
// Assumes pad i belongs to the even group when i is even.
module pwm_pin_cond_chk #(
    parameter int NUM_PINS = 6
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NUM_PINS-1:0] wave_in,
    input logic [NUM_PINS-1:0] pin_en,
    input logic                shutdown_in,
    input logic                trig_in,
    input logic                trig_mode_en,
    input logic                hold_until_trig,
    input logic                pol_ace,
    input logic                pol_bdf,
    input logic [1:0]          sd_mode_ace,
    input logic [1:0]          sd_mode_bdf,
    input logic [NUM_PINS-1:0] pad_out,
    input logic [NUM_PINS-1:0] pad_oe
);

    function automatic logic [NUM_PINS-1:0] grp_mask(input int g);
        logic [NUM_PINS-1:0] m;
        for (int i = 0; i < NUM_PINS; i++) m[i] = ((i % 2) == g);
        return m;
    endfunction

    localparam logic [NUM_PINS-1:0] EVEN_M = grp_mask(0);
    localparam logic [NUM_PINS-1:0] ODD_M  = grp_mask(1);

    logic [NUM_PINS-1:0] pol_vec;
    always_comb pol_vec = ({NUM_PINS{pol_ace}} & EVEN_M) | ({NUM_PINS{pol_bdf}} & ODD_M);

    // R12
    pad_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe & ~pin_en) == '0) && ((pad_out & ~pad_oe) == '0));

    // R3 R11
    even_force_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shutdown_in && sd_mode_ace == 2'b11) |->
        (((pad_oe ^ pin_en) & EVEN_M) == '0) &&
        (((pad_out ^ {NUM_PINS{~pol_ace}}) & pin_en & EVEN_M) == '0));

    // R4
    even_force_inact_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shutdown_in && sd_mode_ace == 2'b10) |->
        (((pad_oe ^ pin_en) & EVEN_M) == '0) &&
        (((pad_out ^ {NUM_PINS{pol_ace}}) & pin_en & EVEN_M) == '0));

    // R5
    odd_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shutdown_in && !sd_mode_bdf[1]) |-> ((pad_oe & ODD_M) == '0));

    // R1 R10
    follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!shutdown_in && (!hold_until_trig || !trig_mode_en)) |->
        (pad_oe == pin_en) && (pad_out == ((wave_in ^ pol_vec) & pin_en)));

    // R9
    rehold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(trig_mode_en) && trig_mode_en && hold_until_trig && !shutdown_in)
        |-> (pad_oe == '0));

    // R8
    armed_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(trig_in && trig_mode_en) && trig_mode_en && !shutdown_in)
        |-> (pad_oe == pin_en));

endmodule

bind pwm_pin_cond pwm_pin_cond_chk #(.NUM_PINS(NUM_PINS)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .wave_in         (wave_in),
    .pin_en          (pin_en),
    .shutdown_in     (shutdown_in),
    .trig_in         (trig_in),
    .trig_mode_en    (trig_mode_en),
    .hold_until_trig (hold_until_trig),
    .pol_ace         (pol_ace),
    .pol_bdf         (pol_bdf),
    .sd_mode_ace     (sd_mode_ace),
    .sd_mode_bdf     (sd_mode_bdf),
    .pad_out         (pad_out),
    .pad_oe          (pad_oe)
);

// File: tb/pwm_pin_cond_test.sv
// Directed bench for pwm_pin_cond: one task per scenario, each self-checking.
module pwm_pin_cond_test;

    localparam int NP = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] wave_in = '0;
    logic [NP-1:0] pin_en = '1;
    logic          shutdown_in = 1'b0;
    logic          trig_in = 1'b0;
    logic          trig_mode_en = 1'b0;
    logic          hold_until_trig = 1'b0;
    logic          pol_ace = 1'b0;
    logic          pol_bdf = 1'b0;
    logic [1:0]    sd_mode_ace = 2'b00;
    logic [1:0]    sd_mode_bdf = 2'b00;
    logic [NP-1:0] pad_out;
    logic [NP-1:0] pad_oe;

    int  vectors = 0;
    int  fails = 0;
    bit  done = 1'b0;
    logic arm_exp = 1'b0;

    always #4 clk = ~clk;

    pwm_pin_cond #(.NUM_PINS(NP)) uut (
        .clk(clk), .rst_n(rst_n), .wave_in(wave_in), .pin_en(pin_en),
        .shutdown_in(shutdown_in), .trig_in(trig_in), .trig_mode_en(trig_mode_en),
        .hold_until_trig(hold_until_trig), .pol_ace(pol_ace), .pol_bdf(pol_bdf),
        .sd_mode_ace(sd_mode_ace), .sd_mode_bdf(sd_mode_bdf),
        .pad_out(pad_out), .pad_oe(pad_oe)
    );

    // Expected pads from the requirements, given the expected armed state.
    task automatic expect_pads(output logic [NP-1:0] o, output logic [NP-1:0] e);
        for (int i = 0; i < NP; i++) begin
            logic p;
            logic [1:0] m;
            p = (i % 2 == 0) ? pol_ace : pol_bdf;
            m = (i % 2 == 0) ? sd_mode_ace : sd_mode_bdf;
            o[i] = 1'b0;
            e[i] = 1'b0;
            if (pin_en[i]) begin
                if (shutdown_in) begin
                    if (m == 2'b11)      begin o[i] = ~p; e[i] = 1'b1; end
                    else if (m == 2'b10) begin o[i] = p;  e[i] = 1'b1; end
                end else if (!(hold_until_trig && trig_mode_en && !arm_exp)) begin
                    o[i] = wave_in[i] ^ p;
                    e[i] = 1'b1;
                end
            end
        end
    endtask

    task automatic check(input string tag);
        logic [NP-1:0] eo, ee;
        expect_pads(eo, ee);
        vectors++;
        if (pad_out !== eo || pad_oe !== ee) begin
            fails++;
            $display("FAIL %s: out=%b oe=%b expected out=%b oe=%b", tag, pad_out, pad_oe, eo, ee);
        end
    endtask

    // Move to the next falling edge, where inputs are changed.
    task automatic at_neg();
        @(negedge clk);
    endtask

    task automatic settle_check(input string tag);
        #1;
        check(tag);
    endtask

    task automatic t_reset();
        trig_mode_en = 1'b1; hold_until_trig = 1'b1; wave_in = 6'b101101;
        trig_in = 1'b1;
        repeat (3) at_neg();
        arm_exp = 1'b0;
        settle_check("R13 held during reset");
        at_neg(); trig_in = 1'b0; rst_n = 1'b1;
        settle_check("R13 armed clear after reset");
        at_neg();
        settle_check("R7 held after reset");
        trig_mode_en = 1'b0; hold_until_trig = 1'b0;
        at_neg();
    endtask

    task automatic t_normal();
        logic [NP-1:0] pats [4] = '{6'b000000, 6'b111111, 6'b101010, 6'b010011};
        for (int k = 0; k < 4; k++) begin
            at_neg();
            wave_in = pats[k]; pol_ace = k[0]; pol_bdf = k[1];
            settle_check("R1 R2 waveform with polarity");
        end
        at_neg(); trig_in = 1'b1; hold_until_trig = 1'b1;
        settle_check("R10 hold bit without triggered mode");
        at_neg(); trig_in = 1'b0; hold_until_trig = 1'b0; trig_mode_en = 1'b1;
        settle_check("R10 triggered mode without hold bit");
        at_neg(); trig_mode_en = 1'b0;
        settle_check("R10 trigger ignored");
    endtask

    task automatic t_shutdown();
        wave_in = 6'b110010;
        for (int c = 0; c < 16; c++) begin
            at_neg();
            sd_mode_ace = c[1:0]; sd_mode_bdf = c[3:2];
            pol_ace = c[0] ^ c[2]; pol_bdf = c[1];
            shutdown_in = 1'b1;
            settle_check("R3 R4 R5 shutdown codes per group");
            at_neg(); shutdown_in = 1'b0;
            settle_check("R6 release in same cycle");
        end
    endtask

    task automatic t_hold();
        at_neg(); trig_mode_en = 1'b1; hold_until_trig = 1'b1; wave_in = 6'b011011;
        arm_exp = 1'b0;
        settle_check("R7 held before trigger");
        at_neg(); sd_mode_ace = 2'b11; sd_mode_bdf = 2'b10; shutdown_in = 1'b1;
        settle_check("R11 shutdown overrides hold");
        at_neg(); shutdown_in = 1'b0;
        settle_check("R7 held again after shutdown");
        at_neg(); trig_in = 1'b1;
        settle_check("R8 not yet armed in trigger cycle");
        at_neg(); trig_in = 1'b0; arm_exp = 1'b1;
        settle_check("R8 released after trigger");
        repeat (3) at_neg();
        wave_in = 6'b100110;
        settle_check("R8 stays armed");
        at_neg(); trig_mode_en = 1'b0; arm_exp = 1'b0;
        settle_check("R10 mode off");
        at_neg(); trig_mode_en = 1'b1;
        settle_check("R9 held again on re-entry");
        at_neg(); trig_in = 1'b1;
        at_neg(); trig_in = 1'b0; arm_exp = 1'b1;
        settle_check("R9 rearmed by new trigger");
    endtask

    task automatic t_pin_en();
        at_neg(); pin_en = 6'b010110; wave_in = 6'b111111;
        settle_check("R12 disabled pads while armed");
        at_neg(); shutdown_in = 1'b1; sd_mode_ace = 2'b11; sd_mode_bdf = 2'b11;
        settle_check("R12 disabled pads under shutdown");
        at_neg(); shutdown_in = 1'b0; trig_mode_en = 1'b0; arm_exp = 1'b0;
        at_neg(); trig_mode_en = 1'b1;
        settle_check("R12 disabled pads while held");
        at_neg(); trig_mode_en = 1'b0; hold_until_trig = 1'b0; pin_en = 6'b101001;
        wave_in = 6'b001100; pol_ace = 1'b1; pol_bdf = 1'b0;
        settle_check("R12 R1 partial enable");
    endtask

    initial begin
        t_reset();
        t_normal();
        t_shutdown();
        t_hold();
        t_pin_en();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog: out=%b oe=%b expected completion", pad_out, pad_oe);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule